// File: doc/BRIEF.md
# Vector Element Address and Mask Sequencer

This block drives the per-element loop of a three-operand vector operation whose register operand is a 16-entry vector register. A one-cycle start pulse hands it a pair of 4-bit selector fields, a base byte address, an element-width code and a stride count. From the selector pair it picks one of three modes. The first is a contiguous run of vector-register entries. The second and third use a 16-bit element mask that comes from the low bits of a general register, taken from the lower eight or the upper eight registers. It also rejects selector pairs that have no meaning.

After the start pulse it emits one element per clock. For each element it gives the vector-register entry number, the memory byte address of the paired memory element, and an enable flag that says whether the arithmetic should act on that element. Memory element zero always pairs with the first register processed. Every later element lies one step further on, where the step is the element width times one plus the stride count. A single-cycle done pulse follows the last element. An arithmetic datapath and a memory port, both outside this block, use the strobes.

Top module: `vseq_elem_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `elem_valid_o`, `elem_en_o`, `done_o` and `illegal_o` are all 0.
- R2: Range mode applies when `sel_a_i` is below 14 and `sel_a_i` <= `sel_b_i`. It emits one element per cycle, with `elem_idx_o` running from `sel_a_i` up to `sel_b_i` and `elem_en_o` = 1 on each. The run has `sel_b_i` - `sel_a_i` + 1 elements, and the first appears in the cycle after the start pulse.
- R3: The k-th emitted element (k counted from 0) has `elem_addr_o` = base + k*step, modulo 2^ADDR_W. In range mode the first register processed therefore gets the base address, whatever its number.
- R4: When `sel_a_i` = 14 and `sel_b_i` is 0..7, `gr_idx_o` = `sel_b_i`. When `sel_a_i` = 15 and `sel_b_i` is 0..7, `gr_idx_o` = 8 + `sel_b_i`. In either case, mask bit i of `gr_mask_i`, sampled at the start pulse, becomes `elem_en_o` for element i.
- R5: Mask mode always emits exactly 16 elements with `elem_idx_o` = 0..15. Elements whose mask bit is 0 still appear with `elem_valid_o` = 1 and `elem_en_o` = 0, and the address still advances past them.
- R6: The step in bytes is (`stride_i` + 1) * W. W is 4 for `width_i` = 0, 8 for `width_i` = 1, and 16 for `width_i` = 2 or 3. A stride count of 0 gives contiguous elements.
- R7: Some selector pairs are illegal: `sel_a_i` below 14 with `sel_a_i` > `sel_b_i`, or `sel_a_i` of 14 or 15 with `sel_b_i` > 7. For these, `illegal_o` and `done_o` are both 1 for the single cycle after the start pulse, and no element is emitted.
- R8: `done_o` is 1 for exactly one cycle, the cycle right after the last element, and `elem_valid_o` is 0 in that cycle.
- R9: A start pulse that arrives while elements are being emitted is ignored, and so are changes to the other inputs in that time. The run in progress completes unchanged and no further run follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a vector operation |
| sel_a_i | input | FIELD_W | First selector field (range start or mask-mode code) |
| sel_b_i | input | FIELD_W | Second selector field (range end or mask register number) |
| base_i | input | ADDR_W | Byte address of memory element zero |
| width_i | input | 2 | Element width code: 0 = 4 B, 1 = 8 B, 2/3 = 16 B |
| stride_i | input | STRIDE_W | Number of element widths skipped between elements |
| gr_idx_o | output | FIELD_W | General register number to read for the mask |
| gr_mask_i | input | NUM_ELEM | Low bits of the general register named by `gr_idx_o` |
| elem_valid_o | output | 1 | An element is presented this cycle |
| elem_idx_o | output | FIELD_W | Vector-register entry of the element |
| elem_addr_o | output | ADDR_W | Memory byte address of the element |
| elem_en_o | output | 1 | Operation acts on this element |
| done_o | output | 1 | One-cycle pulse after the last element |
| illegal_o | output | 1 | Selector pair was illegal (with `done_o`) |

## Verification
The sequencer is tried with range runs at the extreme positions (a single entry, a range starting past zero, the full sixteen entries), with masks from both halves of the register file (a mixed pattern, all zeros and all ones), and with every illegal selector class. The range runs show that the address pairing does not depend on the register number. The mask runs separate skipped elements from dropped elements, and show whether the register is picked from the low or the high half. Random selector pairs, widths and strides are mixed in, some with a repeated start pulse and scrambled inputs during the run. These show whether the step is scaled correctly and whether the sampled operands are held for the whole run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        VMODE_RANGE = 2'd0,
        VMODE_MASK  = 2'd1,
        VMODE_BAD   = 2'd2
    } vmode_e;

    // log2 of the narrowest element in bytes
    localparam int unsigned ELEM_LOG_MIN = 2;

endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
    import vseq_pkg::*;
#(
    parameter int unsigned FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] sel_a_i,
    input  logic [FIELD_W-1:0] sel_b_i,
    output vmode_e             mode_o,
    output logic               mask_hi_o,
    output logic [FIELD_W-1:0] first_o,
    output logic [FIELD_W-1:0] last_o,
    output logic [FIELD_W-1:0] gr_idx_o
);

    localparam int unsigned NUM_ELEM = 1 << FIELD_W;
    localparam logic [FIELD_W-1:0] CODE_MASK_LO = FIELD_W'(NUM_ELEM - 2);
    localparam logic [FIELD_W-1:0] CODE_MASK_HI = FIELD_W'(NUM_ELEM - 1);
    localparam logic [FIELD_W-1:0] GR_HALF      = FIELD_W'(NUM_ELEM / 2);

    logic is_mask_lo;
    logic is_mask_hi;
    logic reg_ok;

    always_comb begin
        is_mask_lo = (sel_a_i == CODE_MASK_LO);
        is_mask_hi = (sel_a_i == CODE_MASK_HI);
        reg_ok     = (sel_b_i < GR_HALF);

        if (is_mask_lo || is_mask_hi) begin
            mode_o  = reg_ok ? VMODE_MASK : VMODE_BAD;
            first_o = '0;
            last_o  = CODE_MASK_HI;
        end else begin
            mode_o  = (sel_a_i <= sel_b_i) ? VMODE_RANGE : VMODE_BAD;
            first_o = sel_a_i;
            last_o  = sel_b_i;
        end

        mask_hi_o = is_mask_hi;
        gr_idx_o  = {is_mask_hi, sel_b_i[FIELD_W-2:0]};
    end

endmodule

// File: rtl/vseq_step.sv
module vseq_step
    import vseq_pkg::*;
#(
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned STEP_W   = STRIDE_W + 5
) (
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [1:0]          width_i,
    output logic [STEP_W-1:0]   step_o
);

    logic [2:0]        shift;
    logic [STEP_W-1:0] span;

    always_comb begin
        unique case (width_i)
            2'd0:    shift = 3'(ELEM_LOG_MIN);
            2'd1:    shift = 3'(ELEM_LOG_MIN + 1);
            default: shift = 3'(ELEM_LOG_MIN + 2);
        endcase
        span   = STEP_W'(stride_i) + STEP_W'(1);
        step_o = span << shift;
    end

endmodule

// File: rtl/vseq_elem_seq.sv
module vseq_elem_seq
    import vseq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned FIELD_W  = 4,
    parameter int unsigned NUM_ELEM = 1 << FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [FIELD_W-1:0]  sel_a_i,
    input  logic [FIELD_W-1:0]  sel_b_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [1:0]          width_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [FIELD_W-1:0]  gr_idx_o,
    input  logic [NUM_ELEM-1:0] gr_mask_i,
    output logic                elem_valid_o,
    output logic [FIELD_W-1:0]  elem_idx_o,
    output logic [ADDR_W-1:0]   elem_addr_o,
    output logic                elem_en_o,
    output logic                done_o,
    output logic                illegal_o
);

    localparam int unsigned STEP_W = STRIDE_W + 5;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic                bad;
        logic                mask_mode;
        logic [FIELD_W-1:0]  idx;
        logic [FIELD_W-1:0]  last;
        logic [NUM_ELEM-1:0] mask;
        logic [ADDR_W-1:0]   addr;
        logic [STEP_W-1:0]   step;
    } seq_state_t;

    seq_state_t st_d, st_q;

    vmode_e             dec_mode;
    logic               dec_mask_hi;
    logic [FIELD_W-1:0] dec_first;
    logic [FIELD_W-1:0] dec_last;
    logic [STEP_W-1:0]  new_step;

    vseq_decode #(
        .FIELD_W (FIELD_W)
    ) i_decode (
        .sel_a_i   (sel_a_i),
        .sel_b_i   (sel_b_i),
        .mode_o    (dec_mode),
        .mask_hi_o (dec_mask_hi),
        .first_o   (dec_first),
        .last_o    (dec_last),
        .gr_idx_o  (gr_idx_o)
    );

    vseq_step #(
        .STRIDE_W (STRIDE_W),
        .STEP_W   (STEP_W)
    ) i_step (
        .stride_i (stride_i),
        .width_i  (width_i),
        .step_o   (new_step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.bad  = 1'b0;

        if (st_q.busy) begin
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx  = st_q.idx + FIELD_W'(1);
                st_d.addr = st_q.addr + ADDR_W'(st_q.step);
            end
        end else if (start_i) begin
            if (dec_mode == VMODE_BAD) begin
                st_d.done = 1'b1;
                st_d.bad  = 1'b1;
            end else begin
                st_d.busy      = 1'b1;
                st_d.mask_mode = (dec_mode == VMODE_MASK);
                st_d.idx       = dec_first;
                st_d.last      = dec_last;
                st_d.mask      = (dec_mode == VMODE_MASK) ? gr_mask_i : '1;
                st_d.addr      = base_i;
                st_d.step      = new_step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elem_valid_o = st_q.busy;
    assign elem_idx_o   = st_q.idx;
    assign elem_addr_o  = st_q.addr;
    assign elem_en_o    = st_q.busy & st_q.mask[st_q.idx];
    assign done_o       = st_q.done;
    assign illegal_o    = st_q.bad;

    // R2: consecutive elements walk the register index upward by one
    p_idx_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && $past(elem_valid_o)) |-> (elem_idx_o == $past(elem_idx_o) + FIELD_W'(1)));

    // R2: outside mask mode every presented element is enabled
    p_range_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && !st_q.mask_mode) |-> elem_en_o);

    // R3: the address moves by the latched step between consecutive elements
    p_addr_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && $past(elem_valid_o))
            |-> (elem_addr_o == $past(elem_addr_o) + ADDR_W'($past(st_q.step))));

    // R7: an illegal flag is always reported together with done and no element
    p_illegal_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !elem_valid_o));

    // R8: the end of a run is followed at once by a done pulse
    p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(elem_valid_o) |-> (done_o && !illegal_o));

    // R8: done never overlaps a presented element
    p_done_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !elem_valid_o);

    // R9: while a run is active the step it uses stays fixed
    p_step_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && $past(elem_valid_o)) |-> $stable(st_q.step));

endmodule

// File: tb/test_vseq_elem_seq.sv
module test_vseq_elem_seq;

    localparam int unsigned ADDR_W   = 40;
    localparam int unsigned STRIDE_W = 16;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned NUM_ELEM = 16;
    localparam time         CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [FIELD_W-1:0]  sel_a = '0;
    logic [FIELD_W-1:0]  sel_b = '0;
    logic [ADDR_W-1:0]   base = '0;
    logic [1:0]          width = '0;
    logic [STRIDE_W-1:0] stride = '0;
    logic [FIELD_W-1:0]  gr_idx;
    logic [NUM_ELEM-1:0] gr_mask;
    logic                e_valid;
    logic [FIELD_W-1:0]  e_idx;
    logic [ADDR_W-1:0]   e_addr;
    logic                e_en;
    logic                done;
    logic                illegal;

    logic [31:0] gr_file [16];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb gr_mask = gr_file[gr_idx][NUM_ELEM-1:0];

    vseq_elem_seq #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .FIELD_W  (FIELD_W)
    ) i_vseq_elem_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .sel_a_i      (sel_a),
        .sel_b_i      (sel_b),
        .base_i       (base),
        .width_i      (width),
        .stride_i     (stride),
        .gr_idx_o     (gr_idx),
        .gr_mask_i    (gr_mask),
        .elem_valid_o (e_valid),
        .elem_idx_o   (e_idx),
        .elem_addr_o  (e_addr),
        .elem_en_o    (e_en),
        .done_o       (done),
        .illegal_o    (illegal)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_step(input int unsigned s, input int unsigned w);
        int unsigned bytes;
        bytes = (w == 0) ? 4 : (w == 1) ? 8 : 16;
        return longint'(s + 1) * longint'(bytes);
    endfunction

    function automatic longint addr_of(input longint b, input int k, input longint st);
        longint full;
        full = b + longint'(k) * st;
        return full & ((longint'(1) << ADDR_W) - 1);
    endfunction

    task automatic run_op(input int a, input int b, input longint bs, input int w,
                          input int s, input bit disturb);
        bit     mmode;
        bit     legal;
        int     first;
        int     n;
        int     gsel;
        logic [15:0] msk;
        longint st;
        mmode = (a >= 14);
        if (mmode) begin
            legal = (b < 8);
            first = 0;
            n     = 16;
            gsel  = (a == 15) ? 8 + (b % 8) : (b % 8);
            msk   = gr_file[gsel][15:0];
        end else begin
            legal = (a <= b);
            first = a;
            n     = b - a + 1;
            gsel  = 0;
            msk   = 16'hFFFF;
        end
        st = exp_step(s, w);

        @(negedge clk);
        sel_a  = FIELD_W'(a);
        sel_b  = FIELD_W'(b);
        base   = ADDR_W'(bs);
        width  = 2'(w);
        stride = STRIDE_W'(s);
        start  = 1'b1;
        #1;
        if (mmode && legal)
            chk(gr_idx == FIELD_W'(gsel), "R4 gr_idx", longint'(gr_idx), longint'(gsel));

        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            chk(done && illegal && !e_valid, "R7 illegal pulse",
                longint'({e_valid, illegal, done}), 64'h3);
            @(negedge clk);
            chk(!done && !illegal && !e_valid, "R7 no elements after illegal",
                longint'({e_valid, illegal, done}), 64'h0);
            return;
        end
        if (disturb) begin
            start  = 1'b1;
            base   = ADDR_W'({$urandom, $urandom});
            stride = STRIDE_W'($urandom);
            width  = 2'($urandom);
            sel_a  = FIELD_W'($urandom);
            sel_b  = FIELD_W'($urandom);
        end
        for (int k = 0; k < n; k++) begin
            chk(e_valid == 1'b1, mmode ? "R5 valid" : "R2 valid", longint'(e_valid), 1);
            chk(e_idx == FIELD_W'(first + k), mmode ? "R5 index" : "R2 index",
                longint'(e_idx), longint'(first + k));
            chk(longint'(e_addr) == addr_of(bs, k, st), disturb ? "R9 address held" : "R3 R6 address",
                longint'(e_addr), addr_of(bs, k, st));
            chk(e_en == msk[first + k], mmode ? "R4 enable from mask" : "R2 enable",
                longint'(e_en), longint'(msk[first + k]));
            chk(!done, "R8 done early", longint'(done), 0);
            start = 1'b0;
            @(negedge clk);
        end
        chk(done && !e_valid && !illegal, "R8 done after last",
            longint'({e_valid, illegal, done}), 64'h1);
        @(negedge clk);
        chk(!done && !e_valid, disturb ? "R9 no second run" : "R8 single done",
            longint'({e_valid, done}), 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) gr_file[i] = $urandom;
        gr_file[3]  = 32'hFFFF_A5C3;
        gr_file[10] = 32'h1234_0F01;
        gr_file[5]  = 32'h0000_0000;
        gr_file[8]  = 32'h0000_FFFF;

        repeat (3) @(negedge clk);
        chk(!e_valid && !e_en && !done && !illegal, "R1 reset outputs",
            longint'({e_valid, e_en, done, illegal}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!e_valid && !e_en && !done && !illegal, "R1 after reset",
            longint'({e_valid, e_en, done, illegal}), 0);

        // R2 R3: range starting past zero, contiguous 4-byte elements
        run_op(3, 9, 64'h10_0000_0000, 0, 0, 1'b0);
        // R2: single element
        run_op(5, 5, 64'h0000_0040, 1, 0, 1'b0);
        // R2 R6: full vector, 16-byte elements with stride
        run_op(0, 15, 64'h00_FFFF_FF00, 2, 3, 1'b0);
        // R6: width code 3 acts as 16 bytes; address wraps
        run_op(13, 13, 64'hFF_FFFF_FFF0, 3, 1, 1'b0);
        run_op(12, 13, 64'hFF_FFFF_FFF0, 3, 1, 1'b0);
        // R4 R5: mask from lower half, mixed mask
        run_op(14, 3, 64'h00_0000_1000, 0, 2, 1'b0);
        // R4: mask from upper half
        run_op(15, 2, 64'h00_0000_2000, 1, 0, 1'b0);
        // R5: all-zero mask still walks 16 elements
        run_op(14, 5, 64'h00_0000_3000, 2, 0, 1'b0);
        // R4: upper half register 8, all ones
        run_op(15, 0, 64'h00_0000_4000, 0, 0, 1'b0);
        // R7: illegal classes
        run_op(9, 2, 64'h0, 0, 0, 1'b0);
        run_op(14, 9, 64'h0, 0, 0, 1'b0);
        run_op(15, 15, 64'h0, 0, 0, 1'b0);
        // R9: start and inputs scrambled while busy
        run_op(2, 11, 64'h00_0000_8000, 1, 5, 1'b1);
        run_op(14, 3, 64'h00_0000_9000, 0, 1, 1'b1);
        run_op(7, 7, 64'h00_0000_A000, 0, 0, 1'b1);

        for (int i = 0; i < 80; i++) begin
            int a;
            int b;
            a = int'($urandom % 16);
            b = int'($urandom % 16);
            if (($urandom % 4) != 0 && a < 14 && a > b) b = a + int'($urandom % (16 - a));
            run_op(a, b, longint'({$urandom, $urandom}) & ((longint'(1) << ADDR_W) - 1),
                   int'($urandom % 4), int'($urandom % 9), 1'(($urandom % 3) == 0));
            if ((i % 10) == 9) gr_file[$urandom % 16] = $urandom;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule